// File: doc/BRIEF.md
# Extended MMC3 Bank Mapper

This block holds the bank registers of an MMC3-style cartridge mapper and turns CPU and PPU addresses into bank numbers. The CPU writes an index and a set of swap flags to the even register in the $8000-$9FFF window. It then writes a bank value to the odd register, and the value lands in the bank register that the index picks. The block looks at CPU address bits A15..A13 and PPU address bits A12..A10. From these, combinationally, it produces an 8 KiB PRG bank number and a 1 KiB CHR bank number.

Two layouts share the same register file. In standard mode there are eight bank registers. The CHR space uses two 2 KiB banks and four 1 KiB banks. The two upper PRG slots are fixed at the second-last and last bank of the outer region. Bank numbers are masked to the outer region size and merged with an outer base. Extended mode adds four registers: two 1 KiB CHR banks and two PRG banks for the slots that are otherwise fixed. In this mode the full eight-bit bank value is ORed with the unmasked outer base. The outer base and size, and the extended-mode enable, come from a neighbouring register block as inputs.

Top module: `ext_mmc3_bank_map`

## Requirements
- R1: After reset, bank registers 0 to 11 hold 00,02,04,05,06,07,00,01,FE,FF,FF,FF (hex). The select index and both swap flags are 0.
- R2: A write to an even address in $8000-$9FFF stores the index from data bits 3..0, the PRG swap flag from bit 6 and the CHR swap flag from bit 7. The next write to an odd address in that window stores the data byte in the indexed bank register.
- R3: In standard mode the PRG slots, indexed by CPU A14..A13, are 0 → register 6, 1 → register 7, 2 → bank FE and 3 → bank FF. With the PRG swap flag set, slots 0 and 2 trade places.
- R4: In standard mode registers 0 and 1 ignore their bit 0. Each covers two consecutive 1 KiB pages: bit 0 cleared for the lower page and set for the upper page. PPU slots 0-1 take register 0, slots 2-3 take register 1, and slots 4 to 7 take registers 2 to 5. The CHR swap flag inverts PPU A12 before this lookup.
- R5: In extended mode the PRG slots are 0 → register 6, 1 → register 7, 2 → register 8 and 3 → register 9. With the PRG swap flag set, slots 0 and 2 trade places.
- R6: In extended mode the PPU slots are 0 → register 0, 1 → register 10, 2 → register 1, 3 → register 11, and 4 to 7 → registers 2 to 5. The CHR swap flag inverts PPU A12 first.
- R7: In standard mode the PRG bank is (raw AND m) OR (base AND NOT m). The mask m is 3F for size code 0, 1F for code 1 and 0F for codes 2 and 3. The CHR bank uses m = FF for size 0 and 7F for size 1. So with base 0 and size code 0, CPU $E000 maps to bank 3F.
- R8: In extended mode the PRG bank and the CHR bank are raw OR base, with no mask applied.
- R9: In extended mode a data write while the index is 12 to 15 changes no register. In standard mode only index bits 2..0 count.
- R10: Writes whose address has A15..A13 other than 100 (binary) change neither the index nor any bank register.
- R11: When CPU A15 is 0, the PRG bank output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_wa | input | 16 | CPU write address |
| cpu_wd | input | 8 | CPU write data |
| ext_en | input | 1 | Extended layout enable |
| prg_size | input | 2 | Outer PRG region size code |
| prg_base | input | PRG_BW | Outer PRG base, in 8 KiB units |
| chr_size | input | 1 | Outer CHR region size code |
| chr_base | input | CHR_BW | Outer CHR base, in 1 KiB units |
| cpu_a | input | 3 | CPU A15..A13 |
| ppu_a | input | 3 | PPU A12..A10 |
| prg_bank | output | PRG_BW | 8 KiB PRG bank number |
| chr_bank | output | CHR_BW | 1 KiB CHR bank number |

## Verification
Each scenario sweeps all eight CPU slots and all eight PPU slots. The bank registers are loaded with distinct values, with both odd and even low bits, so a wrong slot-to-register route shows up as a wrong number. Both layouts are run with each swap flag clear and then set. This separates the fixed-slot logic from the register-fed slots, and the pairing of standard mode from the 1 KiB banks of extended mode. Outer bases with ones in the masked bits are combined with each size code, which tells masking apart from plain OR. Writes to foreign windows, to indices 12 to 15, and through index bit 3 in standard mode show which writes the decoder accepts.

// File: rtl/ext_mmc3_pkg.sv
package ext_mmc3_pkg;
  localparam int NREG = 12;
  localparam int IDXW = 4;

  typedef logic [7:0] bank_t;

  function automatic bank_t rst_val(input int i);
    if (i < 2)       return bank_t'(2 * i);
    else if (i < 6)  return bank_t'(i + 2);
    else if (i == 6) return 8'h00;
    else if (i == 7) return 8'h01;
    else if (i == 8) return 8'hFE;
    else             return 8'hFF;
  endfunction

  function automatic bank_t prg_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 8'h3F;
      2'd1:    return 8'h1F;
      default: return 8'h0F;
    endcase
  endfunction

  function automatic bank_t chr_mask(input logic sz);
    return sz ? 8'h7F : 8'hFF;
  endfunction
endpackage

// File: rtl/emb_reg_file.sv
module emb_reg_file
  import ext_mmc3_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_we,
  input  logic                  dat_we,
  input  logic                  ext_en,
  input  logic [7:0]            wd,
  output logic [IDXW-1:0]       sel_idx,
  output logic                  prg_inv,
  output logic                  chr_inv,
  output logic [NREG-1:0][7:0]  bank_q
);
  logic [IDXW-1:0]      idx_d, idx_q;
  logic                 pinv_d, pinv_q, cinv_d, cinv_q;
  logic [NREG-1:0][7:0] bank_d;
  logic [IDXW-1:0]      idx_eff;
  logic                 idx_ok;

  always_comb begin
    idx_eff = ext_en ? idx_q : {1'b0, idx_q[2:0]};
    idx_ok  = (idx_eff < IDXW'(NREG));
    idx_d   = idx_q;
    pinv_d  = pinv_q;
    cinv_d  = cinv_q;
    bank_d  = bank_q;
    if (sel_we) begin
      idx_d  = wd[3:0];
      pinv_d = wd[6];
      cinv_d = wd[7];
    end
    if (dat_we && idx_ok)
      bank_d[idx_eff] = wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      pinv_q <= 1'b0;
      cinv_q <= 1'b0;
    end else if (sel_we) begin
      idx_q  <= idx_d;
      pinv_q <= pinv_d;
      cinv_q <= cinv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= rst_val(i);
    end else if (dat_we) begin
      bank_q <= bank_d;
    end
  end

  assign sel_idx = idx_q;
  assign prg_inv = pinv_q;
  assign chr_inv = cinv_q;
endmodule

// File: rtl/emb_prg_map.sv
module emb_prg_map
  import ext_mmc3_pkg::*;
#(
  parameter int PRG_BW = 10
) (
  input  logic                 ext_en,
  input  logic                 prg_inv,
  input  logic [NREG-1:0][7:0] bank_q,
  input  logic [2:0]           cpu_a,
  input  logic [1:0]           prg_size,
  input  logic [PRG_BW-1:0]    prg_base,
  output logic [PRG_BW-1:0]    prg_bank
);
  localparam int PADW = PRG_BW - 8;

  bank_t             raw, alt8, msk;
  logic [PRG_BW-1:0] raw_w, msk_w;

  always_comb begin
    alt8 = ext_en ? bank_q[8] : 8'hFE;
    unique case (cpu_a[1:0])
      2'd0: raw = prg_inv ? alt8 : bank_q[6];
      2'd1: raw = bank_q[7];
      2'd2: raw = prg_inv ? bank_q[6] : alt8;
      default: raw = ext_en ? bank_q[9] : 8'hFF;
    endcase
    msk   = prg_mask(prg_size);
    raw_w = {{PADW{1'b0}}, raw};
    msk_w = {{PADW{1'b0}}, msk};
    if (!cpu_a[2])
      prg_bank = '0;
    else if (ext_en)
      prg_bank = raw_w | prg_base;
    else
      prg_bank = (raw_w & msk_w) | (prg_base & ~msk_w);
  end
endmodule

// File: rtl/emb_chr_map.sv
module emb_chr_map
  import ext_mmc3_pkg::*;
#(
  parameter int CHR_BW = 11
) (
  input  logic                 ext_en,
  input  logic                 chr_inv,
  input  logic [NREG-1:0][7:0] bank_q,
  input  logic [2:0]           ppu_a,
  input  logic                 chr_size,
  input  logic [CHR_BW-1:0]    chr_base,
  output logic [CHR_BW-1:0]    chr_bank
);
  localparam int PADW = CHR_BW - 8;

  logic [2:0]        slot;
  bank_t             raw, msk;
  logic [CHR_BW-1:0] raw_w, msk_w;

  always_comb begin
    slot = ppu_a ^ {chr_inv, 2'b00};
    unique case (slot)
      3'd0: raw = ext_en ? bank_q[0]  : {bank_q[0][7:1], 1'b0};
      3'd1: raw = ext_en ? bank_q[10] : {bank_q[0][7:1], 1'b1};
      3'd2: raw = ext_en ? bank_q[1]  : {bank_q[1][7:1], 1'b0};
      3'd3: raw = ext_en ? bank_q[11] : {bank_q[1][7:1], 1'b1};
      3'd4: raw = bank_q[2];
      3'd5: raw = bank_q[3];
      3'd6: raw = bank_q[4];
      default: raw = bank_q[5];
    endcase
    msk   = chr_mask(chr_size);
    raw_w = {{PADW{1'b0}}, raw};
    msk_w = {{PADW{1'b0}}, msk};
    if (ext_en)
      chr_bank = raw_w | chr_base;
    else
      chr_bank = (raw_w & msk_w) | (chr_base & ~msk_w);
  end
endmodule

// File: rtl/ext_mmc3_bank_map.sv
module ext_mmc3_bank_map
  import ext_mmc3_pkg::*;
#(
  parameter int PRG_BW = 10,
  parameter int CHR_BW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_wa,
  input  logic [7:0]        cpu_wd,
  input  logic              ext_en,
  input  logic [1:0]        prg_size,
  input  logic [PRG_BW-1:0] prg_base,
  input  logic              chr_size,
  input  logic [CHR_BW-1:0] chr_base,
  input  logic [2:0]        cpu_a,
  input  logic [2:0]        ppu_a,
  output logic [PRG_BW-1:0] prg_bank,
  output logic [CHR_BW-1:0] chr_bank
);
  logic [1:0]           rst_sync;
  logic                 rst_int_n;
  logic                 win_hit, sel_we, dat_we;
  logic [IDXW-1:0]      sel_idx;
  logic                 prg_inv, chr_inv;
  logic [NREG-1:0][7:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign win_hit = cpu_wr && (cpu_wa[15:13] == 3'b100);
  assign sel_we  = win_hit && !cpu_wa[0];
  assign dat_we  = win_hit &&  cpu_wa[0];

  emb_reg_file u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel_we  (sel_we),
    .dat_we  (dat_we),
    .ext_en  (ext_en),
    .wd      (cpu_wd),
    .sel_idx (sel_idx),
    .prg_inv (prg_inv),
    .chr_inv (chr_inv),
    .bank_q  (bank_q)
  );

  emb_prg_map #(.PRG_BW(PRG_BW)) u_prg (
    .ext_en   (ext_en),
    .prg_inv  (prg_inv),
    .bank_q   (bank_q),
    .cpu_a    (cpu_a),
    .prg_size (prg_size),
    .prg_base (prg_base),
    .prg_bank (prg_bank)
  );

  emb_chr_map #(.CHR_BW(CHR_BW)) u_chr (
    .ext_en   (ext_en),
    .chr_inv  (chr_inv),
    .bank_q   (bank_q),
    .ppu_a    (ppu_a),
    .chr_size (chr_size),
    .chr_base (chr_base),
    .chr_bank (chr_bank)
  );
endmodule

// File: rtl/emb_checker.sv
module emb_checker
  import ext_mmc3_pkg::*;
#(
  parameter int PRG_BW = 10,
  parameter int CHR_BW = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_wr,
  input logic [15:0]          cpu_wa,
  input logic [7:0]           cpu_wd,
  input logic                 ext_en,
  input logic [1:0]           prg_size,
  input logic [PRG_BW-1:0]    prg_base,
  input logic [CHR_BW-1:0]    chr_base,
  input logic [2:0]           cpu_a,
  input logic [2:0]           ppu_a,
  input logic [PRG_BW-1:0]    prg_bank,
  input logic [CHR_BW-1:0]    chr_bank,
  input logic [IDXW-1:0]      sel_idx,
  input logic                 prg_inv,
  input logic                 chr_inv,
  input logic [NREG-1:0][7:0] bank_q
);
  logic in_win;
  assign in_win = cpu_wr && (cpu_wa[15:13] == 3'b100);

  p_sel_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !cpu_wa[0]) |=> (sel_idx == $past(cpu_wd[3:0]) &&
                                prg_inv == $past(cpu_wd[6]) &&
                                chr_inv == $past(cpu_wd[7])));

  p_hi_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && cpu_wa[0] && ext_en && sel_idx >= 4'd12) |=> $stable(bank_q));

  p_foreign_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |=> ($stable(bank_q) && $stable(sel_idx)));

  p_low_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_a[2] |-> (prg_bank == '0));

  p_last_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && cpu_a == 3'b111 && prg_size == 2'd0 && prg_base == '0)
      |-> (prg_bank == PRG_BW'(8'h3F)));

  p_chr_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && !chr_base[0] && ((ppu_a[2] ^ chr_inv) == 1'b0))
      |-> (chr_bank[0] == ppu_a[0]));
endmodule

bind ext_mmc3_bank_map emb_checker #(.PRG_BW(PRG_BW), .CHR_BW(CHR_BW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_wr   (cpu_wr),
  .cpu_wa   (cpu_wa),
  .cpu_wd   (cpu_wd),
  .ext_en   (ext_en),
  .prg_size (prg_size),
  .prg_base (prg_base),
  .chr_base (chr_base),
  .cpu_a    (cpu_a),
  .ppu_a    (ppu_a),
  .prg_bank (prg_bank),
  .chr_bank (chr_bank),
  .sel_idx  (sel_idx),
  .prg_inv  (prg_inv),
  .chr_inv  (chr_inv),
  .bank_q   (bank_q)
);

// File: tb/ext_mmc3_bank_map_bench.sv
`timescale 1ns/1ps
module ext_mmc3_bank_map_bench;
  localparam int PRG_BW = 10;
  localparam int CHR_BW = 11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cpu_wr;
  logic [15:0]       cpu_wa;
  logic [7:0]        cpu_wd;
  logic              ext_en;
  logic [1:0]        prg_size;
  logic [PRG_BW-1:0] prg_base;
  logic              chr_size;
  logic [CHR_BW-1:0] chr_base;
  logic [2:0]        cpu_a;
  logic [2:0]        ppu_a;
  logic [PRG_BW-1:0] prg_bank;
  logic [CHR_BW-1:0] chr_bank;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] sh [12];
  logic [3:0] sh_idx;
  logic       sh_pinv, sh_cinv;

  always #2 clk = ~clk;

  ext_mmc3_bank_map #(.PRG_BW(PRG_BW), .CHR_BW(CHR_BW)) u_ext_mmc3_bank_map (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wa(cpu_wa), .cpu_wd(cpu_wd),
    .ext_en(ext_en), .prg_size(prg_size), .prg_base(prg_base),
    .chr_size(chr_size), .chr_base(chr_base), .cpu_a(cpu_a), .ppu_a(ppu_a),
    .prg_bank(prg_bank), .chr_bank(chr_bank)
  );

  function automatic logic [PRG_BW-1:0] exp_prg(input logic [2:0] a);
    logic [7:0] raw, m;
    if (!a[2]) return '0;
    case (a[1:0])
      2'd0: raw = sh_pinv ? (ext_en ? sh[8] : 8'hFE) : sh[6];
      2'd1: raw = sh[7];
      2'd2: raw = sh_pinv ? sh[6] : (ext_en ? sh[8] : 8'hFE);
      default: raw = ext_en ? sh[9] : 8'hFF;
    endcase
    m = (prg_size == 2'd0) ? 8'h3F : (prg_size == 2'd1) ? 8'h1F : 8'h0F;
    if (ext_en) return PRG_BW'(raw) | prg_base;
    return (PRG_BW'(raw) & PRG_BW'(m)) | (prg_base & ~PRG_BW'(m));
  endfunction

  function automatic logic [CHR_BW-1:0] exp_chr(input logic [2:0] p);
    logic [2:0] k;
    logic [7:0] raw, m;
    k = p ^ (sh_cinv ? 3'd4 : 3'd0);
    case (k)
      3'd0: raw = ext_en ? sh[0]  : (sh[0] & 8'hFE);
      3'd1: raw = ext_en ? sh[10] : (sh[0] | 8'h01);
      3'd2: raw = ext_en ? sh[1]  : (sh[1] & 8'hFE);
      3'd3: raw = ext_en ? sh[11] : (sh[1] | 8'h01);
      default: raw = sh[k - 3'd2];
    endcase
    m = chr_size ? 8'h7F : 8'hFF;
    if (ext_en) return CHR_BW'(raw) | chr_base;
    return (CHR_BW'(raw) & CHR_BW'(m)) | (chr_base & ~CHR_BW'(m));
  endfunction

  task automatic reset_model();
    for (int i = 0; i < 12; i++)
      sh[i] = (i < 2) ? 8'(2*i) : (i < 6) ? 8'(i+2) : (i == 6) ? 8'h00 :
              (i == 7) ? 8'h01 : (i == 8) ? 8'hFE : 8'hFF;
    sh_idx = 0; sh_pinv = 0; sh_cinv = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [3:0] ie;
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wa = a; cpu_wd = d;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a[15:13] == 3'b100) begin
      if (!a[0]) begin
        sh_idx = d[3:0]; sh_pinv = d[6]; sh_cinv = d[7];
      end else begin
        ie = ext_en ? sh_idx : {1'b0, sh_idx[2:0]};
        if (ie < 4'd12) sh[ie] = d;
      end
    end
  endtask

  task automatic setb(input logic [3:0] idx, input logic [7:0] d, input logic [7:0] fl);
    wr(16'h8000, fl | {4'h0, idx});
    wr(16'h8001, d);
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      cpu_a = 3'(s); ppu_a = 3'(s);
      #1;
      checks++;
      if (prg_bank !== exp_prg(3'(s))) begin
        fails++;
        $display("FAIL %s prg slot %0d actual=%0h expected=%0h", tag, s, prg_bank, exp_prg(3'(s)));
      end
      checks++;
      if (chr_bank !== exp_chr(3'(s))) begin
        fails++;
        $display("FAIL %s chr slot %0d actual=%0h expected=%0h", tag, s, chr_bank, exp_chr(3'(s)));
      end
    end
  endtask

  task automatic load_distinct();
    for (int i = 0; i < 12; i++) setb(4'(i), 8'(8'h31 + 8'(i*13)), 8'h00);
  endtask

  task automatic t_reset();
    ext_en = 0; check_all("R1 std");
    ext_en = 1; check_all("R1 ext");
    ext_en = 0;
  endtask

  task automatic t_std_prg();
    ext_en = 0; load_distinct();
    wr(16'h8000, 8'h00); check_all("R3 R2 noswap");
    wr(16'h8000, 8'h40); check_all("R3 R2 prgswap");
  endtask

  task automatic t_std_chr();
    ext_en = 0;
    wr(16'h8000, 8'h00); check_all("R4 noswap");
    wr(16'h8000, 8'h80); check_all("R4 chrswap");
    wr(16'h8000, 8'hC0); check_all("R4 R3 bothswap");
  endtask

  task automatic t_ext();
    ext_en = 1; load_distinct();
    wr(16'h8000, 8'h00); check_all("R5 R6 noswap");
    wr(16'h8000, 8'h40); check_all("R5 prgswap");
    wr(16'h8000, 8'h80); check_all("R6 chrswap");
    ext_en = 0;
  endtask

  task automatic t_outer_std();
    ext_en = 0;
    prg_base = 10'h3E5; chr_base = 11'h5AB;
    for (int z = 0; z < 4; z++) begin
      prg_size = 2'(z); chr_size = z[0];
      check_all("R7 outer");
    end
    prg_size = 0; chr_size = 0; prg_base = 0; chr_base = 0;
    reset_model_check_last();
  endtask

  task automatic reset_model_check_last();
    @(negedge clk); cpu_a = 3'b111; #1;
    checks++;
    if (prg_bank !== PRG_BW'(8'h3F)) begin
      fails++;
      $display("FAIL R7 last bank actual=%0h expected=3f", prg_bank);
    end
  endtask

  task automatic t_outer_ext();
    ext_en = 1; prg_base = 10'h300; chr_base = 11'h600;
    prg_size = 2'd2; chr_size = 1;
    check_all("R8 outer");
    prg_base = 10'h2AA; chr_base = 11'h455;
    check_all("R8 overlap");
    prg_base = 0; chr_base = 0; prg_size = 0; chr_size = 0; ext_en = 0;
  endtask

  task automatic t_ignore_idx();
    ext_en = 1;
    for (int i = 12; i < 16; i++) setb(4'(i), 8'h5A, 8'h00);
    check_all("R9 hi idx ignored");
    ext_en = 0;
    setb(4'd8, 8'h20, 8'h00);
    setb(4'd14, 8'h47, 8'h00);
    check_all("R9 std idx bits");
  endtask

  task automatic t_decode();
    ext_en = 0;
    wr(16'hA000, 8'hC6); wr(16'hA001, 8'h77);
    wr(16'hC001, 8'h66); wr(16'hE000, 8'h46); wr(16'h6001, 8'h12);
    check_all("R10 foreign");
    wr(16'h9FFE, 8'h06); wr(16'h9FFF, 8'h2C);
    check_all("R10 R2 window edge");
  endtask

  task automatic t_low_cpu();
    ext_en = 1; prg_base = 10'h3FF;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); cpu_a = 3'(s); #1;
      checks++;
      if (prg_bank !== '0) begin
        fails++;
        $display("FAIL R11 slot %0d actual=%0h expected=0", s, prg_bank);
      end
    end
    prg_base = 0; ext_en = 0;
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; cpu_wr = 0; cpu_wa = 0; cpu_wd = 0; ext_en = 0;
    prg_size = 0; prg_base = 0; chr_size = 0; chr_base = 0; cpu_a = 0; ppu_a = 0;
    reset_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_std_prg();
    t_std_chr();
    t_ext();
    t_outer_std();
    t_outer_ext();
    t_ignore_idx();
    t_decode();
    t_low_cpu();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule